// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Initializer

This block keeps an asynchronous DRAM's contents alive and brings the device out of power-up. After reset it waits out a mandatory quiet period, then issues a fixed number of dummy row-strobe cycles on its own authority. Only then does it raise `ready` and hand the memory to the access sequencer. The dummy cycles use the style that the mode input selects, so a system that relies on the device's internal row counter initializes with column-before-row cycles.

In normal operation a periodic timer adds one pending refresh per interval to a saturating backlog. While the backlog is nonzero and no refresh is running, `ref_req` is high. The access sequencer answers with `ref_gnt`, and the block then drives the row and column strobes through one complete refresh cycle. There are two styles. A column-before-row cycle lowers the column strobe ahead of the row strobe. A row-only cycle leaves the column strobe high and puts the block's own 9-bit row counter on the address bus. If the sequencer grants while it is still holding the column strobe low after an access (`cas_held`), the block runs a hidden refresh: the setup phase is skipped and the cycle behaves as column-before-row. `low_power` multiplies the refresh interval for parts with a longer retention spec. `ref_urgent` warns that the backlog is close to full.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PWRUP_CYC cycles after reset, `ready` is low, `ras_n` and `cas_n` are high, and `busy` is low.
- R2: After the pause, exactly INIT_CYCLES refresh cycles run without any grant. `ready` rises once the last of them has finished and then stays high until the next reset.
- R3: Initialization cycles use the style selected by `use_cbr`. With 1 they are column-before-row and the row counter stays at 0. With 0 they are row-only and leave the row counter at INIT_CYCLES.
- R4: A column-before-row cycle holds `cas_n` low for CSR_CYC cycles while `ras_n` is still high. It then holds `ras_n` low for RAS_CYC cycles with `cas_n` kept low, and keeps `addr_en` low throughout.
- R5: A row-only cycle keeps `cas_n` high. It drives `addr_en` high for the CSR_CYC address-setup cycles and the RAS_CYC row-strobe cycles.
- R6: `row_addr` advances by one at the end of each row-only cycle and wraps from 2^ROW_W-1 to 0. Column-before-row and hidden cycles do not change it.
- R7: Once `ready` is high, a refresh tick occurs every INTERVAL_CYC cycles, or every INTERVAL_CYC*LP_MULT cycles while `low_power` is 1.
- R8: `ref_req` is high exactly when `ready` is high, no cycle is running and the backlog is nonzero. A cycle starts only on `ref_req` together with `ref_gnt`, and each completed cycle removes one from the backlog.
- R9: The backlog saturates at BL_MAX. Ticks that arrive while it is full are dropped.
- R10: `ref_urgent` is high exactly when the backlog is at least URG_LIM.
- R11: A grant given while `cas_held` is 1 starts a hidden refresh. `ras_n` falls on the first cycle, `cas_n` is low while `ras_n` is low, and `row_addr` is unchanged.
- R12: Every cycle ends with RP_CYC cycles of precharge with both strobes high, and `busy` stays high until the precharge is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_cbr | input | 1 | 1: column-before-row refresh, 0: row-only refresh |
| low_power | input | 1 | Stretch the refresh interval by LP_MULT |
| ref_gnt | input | 1 | Grant from the access sequencer |
| cas_held | input | 1 | Sequencer still holds the column strobe low (hidden refresh) |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Backlog has reached URG_LIM |
| ready | output | 1 | Initialization complete; memory usable |
| busy | output | 1 | A refresh cycle is running |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_en | output | 1 | Drive `row_addr` onto the address bus |
| row_addr | output | ROW_W | Row counter for row-only refresh |

## Verification
The bench targets the power-up sequence. A design that ends the pause early, counts one dummy cycle too few or too many, or requires a grant during initialization shows the wrong number of row-strobe falls before `ready`. The bench holds the grant off long enough to overflow an unbounded backlog: a design without saturation then drains far more than BL_MAX cycles and keeps `ref_req` high too long. It runs more than 512 row-only refreshes to reach the counter wrap. It issues a hidden refresh in row-only mode, where a design that kept the setup phase or advanced the row counter shows a late `ras_n` fall or a moved `row_addr`. The interval is measured in both timer modes so that a design ignoring `low_power` is exposed.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_SETUP, ENG_ACT, ENG_PRE} eng_st_t;
  typedef enum logic [1:0] {INI_PAUSE, INI_DUMMY, INI_RUN} ini_st_t;
endpackage

// File: rtl/dram_ref_engine.sv
module dram_ref_engine
  import dram_ref_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 13,
  parameter int RP_CYC  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_cbr,
  input  logic             start_hidden,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_en,
  output logic [ROW_W-1:0] row_addr,
  output logic             busy,
  output logic             done
);
  localparam int MAX_A = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAX_C = (MAX_A > RP_CYC) ? MAX_A : RP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  eng_st_t          st;
  logic [CW-1:0]    cnt;
  logic             cbr_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ENG_IDLE;
      cnt   <= '0;
      cbr_q <= 1'b0;
      row_q <= '0;
    end else begin
      case (st)
        ENG_IDLE: if (start) begin
          cbr_q <= start_cbr | start_hidden;
          if (start_hidden) begin
            st  <= ENG_ACT;
            cnt <= CW'(RAS_CYC - 1);
          end else begin
            st  <= ENG_SETUP;
            cnt <= CW'(CSR_CYC - 1);
          end
        end
        ENG_SETUP: if (cnt == '0) begin
          st  <= ENG_ACT;
          cnt <= CW'(RAS_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ENG_ACT: if (cnt == '0) begin
          st  <= ENG_PRE;
          cnt <= CW'(RP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ENG_PRE: if (cnt == '0) begin
          st <= ENG_IDLE;
          if (!cbr_q) row_q <= row_q + 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    ras_n   = (st != ENG_ACT);
    cas_n   = !(cbr_q && (st == ENG_SETUP || st == ENG_ACT));
    addr_en = !cbr_q && (st == ENG_SETUP || st == ENG_ACT);
    busy    = (st != ENG_IDLE);
    done    = (st == ENG_PRE) && (cnt == '0);
  end
  assign row_addr = row_q;

  // R4: whenever the row strobe falls with the column strobe low, no address is driven
  p_cbr_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !addr_en);
  // R5: a row-only cycle never lowers the column strobe
  p_rowonly_cas_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && addr_en) |-> cas_n);
  // R6: the row counter moves only on leaving precharge of a row-only cycle
  p_row_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> $past(st == ENG_PRE && !cbr_q));
  // R12: a row strobe rise is followed by at least one precharge cycle
  p_precharge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL_CYC = 3906,
  parameter int LP_MULT      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic low_power,
  output logic tick
);
  localparam int LONG_CYC = INTERVAL_CYC * LP_MULT;
  localparam int TW       = $clog2(LONG_CYC + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;

  assign lim  = low_power ? TW'(LONG_CYC) : TW'(INTERVAL_CYC);
  assign tick = en && (cnt >= lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R7: the count never passes the long interval
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < TW'(LONG_CYC));
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int BL_MAX  = 8,
  parameter int URG_LIM = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pending,
  output logic urgent
);
  localparam int BW = $clog2(BL_MAX + 1);

  logic [BW-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else if (inc && !dec && level != BW'(BL_MAX)) level <= level + 1'b1;
    else if (dec && !inc && level != '0)         level <= level - 1'b1;
  end

  assign pending = (level != '0);
  assign urgent  = (level >= BW'(URG_LIM));

  // R9: the backlog never exceeds its cap
  p_bl_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    level <= BW'(BL_MAX));
  // R10: urgency implies something is pending
  p_urgent_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> pending);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int ROW_W        = 9,
  parameter int PWRUP_CYC    = 50000,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = 3906,
  parameter int LP_MULT      = 8,
  parameter int CSR_CYC      = 2,
  parameter int RAS_CYC      = 13,
  parameter int RP_CYC       = 9,
  parameter int BL_MAX       = 8,
  parameter int URG_LIM      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_cbr,
  input  logic             low_power,
  input  logic             ref_gnt,
  input  logic             cas_held,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             ready,
  output logic             busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_en,
  output logic [ROW_W-1:0] row_addr
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int DW = $clog2(INIT_CYCLES + 1);

  ini_st_t       ist;
  logic [PW-1:0] pcnt;
  logic [DW-1:0] dcnt;
  logic          run, eng_start, eng_done, tick, pending;

  assign run       = (ist == INI_RUN);
  assign ready     = run;
  assign ref_req   = run && !busy && pending;
  assign eng_start = ((ist == INI_DUMMY) && !busy) || (ref_req && ref_gnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist  <= INI_PAUSE;
      pcnt <= '0;
      dcnt <= '0;
    end else begin
      case (ist)
        INI_PAUSE: if (pcnt == PW'(PWRUP_CYC - 1)) ist <= INI_DUMMY;
                   else pcnt <= pcnt + 1'b1;
        INI_DUMMY: if (eng_done) begin
          if (dcnt == DW'(INI_CYCLES_M1)) ist <= INI_RUN;
          else dcnt <= dcnt + 1'b1;
        end
        default: ist <= INI_RUN;
      endcase
    end
  end
  localparam int INI_CYCLES_M1 = INIT_CYCLES - 1;

  dram_ref_engine #(
    .ROW_W(ROW_W), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .start_cbr(use_cbr),
    .start_hidden(run && cas_held), .ras_n(ras_n), .cas_n(cas_n),
    .addr_en(addr_en), .row_addr(row_addr), .busy(busy), .done(eng_done)
  );

  dram_ref_timer #(.INTERVAL_CYC(INTERVAL_CYC), .LP_MULT(LP_MULT)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(run), .low_power(low_power), .tick(tick)
  );

  dram_ref_backlog #(.BL_MAX(BL_MAX), .URG_LIM(URG_LIM)) u_backlog (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(eng_done && run),
    .pending(pending), .urgent(ref_urgent)
  );

  // R1: strobes stay idle during the power-up pause
  p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ist == INI_PAUSE) |-> (ras_n && cas_n && !busy));
  // R2: once released, the memory stays released
  p_ready_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R8: an ungranted request does not start a cycle
  p_no_start_without_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> !busy);
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int ROW_W = 9, PWRUP = 40, INIT = 8, INTV = 30, LPM = 4;
  localparam int CSR = 2, RAS = 5, RP = 3, BLMAX = 7, URG = 4;
  localparam int NROW = 1 << ROW_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic use_cbr = 1'b1, low_power = 1'b0, ref_gnt = 1'b0, cas_held = 1'b0;
  logic ref_req, ref_urgent, ready, busy, ras_n, cas_n, addr_en;
  logic [ROW_W-1:0] row_addr;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .ROW_W(ROW_W), .PWRUP_CYC(PWRUP), .INIT_CYCLES(INIT), .INTERVAL_CYC(INTV),
    .LP_MULT(LPM), .CSR_CYC(CSR), .RAS_CYC(RAS), .RP_CYC(RP),
    .BL_MAX(BLMAX), .URG_LIM(URG)
  ) dut_i (.*);

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference: phase, power-up count, dummy count, position in cycle
  int m_phase, m_pc, m_dum, m_pos, m_cbr, m_hid, m_row, m_tc, m_bl, m_ticks;

  function automatic int m_len();
    return m_hid ? (RAS + RP) : (CSR + RAS + RP);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_dum = 0; m_pos = -1; m_cbr = 0; m_hid = 0;
      m_row = 0; m_tc = 0; m_bl = 0;
    end else begin
      automatic bit bz = (m_pos >= 0);
      automatic bit dn = bz && (m_pos == m_len() - 1);
      automatic int lim = low_power ? INTV * LPM : INTV;
      automatic bit tk = (m_phase == 2) && (m_tc >= lim - 1);
      automatic bit st = !bz && ((m_phase == 1) || (m_phase == 2 && m_bl > 0 && ref_gnt));
      automatic bit dec = dn && (m_phase == 2);
      if (m_phase == 2) m_tc = tk ? 0 : m_tc + 1; else m_tc = 0;
      if (tk) m_ticks++;
      if (tk && !dec && m_bl < BLMAX) m_bl++;
      else if (dec && !tk && m_bl > 0) m_bl--;
      if (dn) begin
        if (!m_cbr) m_row = (m_row + 1) % NROW;
        m_pos = -1;
      end else if (bz) m_pos++;
      else if (st) begin
        m_pos = 0;
        m_hid = (m_phase == 2) && cas_held;
        m_cbr = use_cbr || m_hid;
      end
      if (m_phase == 0) begin
        if (m_pc == PWRUP - 1) m_phase = 1; else m_pc++;
      end else if (m_phase == 1 && dn) begin
        if (m_dum == INIT - 1) m_phase = 2; else m_dum++;
      end
    end
  end

  // Monitors and per-cycle comparison, sampled on the falling edge
  int ras_falls, cbr_falls, cas_ras_low, gap, min_gap, row_steps_bad, wraps;
  logic p_ras, p_cas; int p_row; bit seen_rise;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ras_falls = 0; cbr_falls = 0; p_ras = 1; p_cas = 1; p_row = 0;
      gap = 0; seen_rise = 0;
    end else begin
      automatic bit bz = (m_pos >= 0);
      automatic bit setup = bz && !m_hid && m_pos < CSR;
      automatic bit act = bz && !setup && (m_hid ? m_pos < RAS : m_pos < CSR + RAS);
      chk(m_hid ? "R11 cas_n" : "R4 cas_n", cas_n, !(m_cbr && (setup || act)));
      chk("R4 ras_n", ras_n, !act);
      chk("R5 addr_en", addr_en, !m_cbr && (setup || act));
      chk("R6 row_addr", row_addr, m_row);
      chk("R2 ready", ready, m_phase == 2);
      chk("R8 ref_req", ref_req, (m_phase == 2) && !bz && m_bl > 0);
      chk("R10 ref_urgent", ref_urgent, m_bl >= URG);
      chk("R12 busy", busy, bz);
      if (p_ras && !ras_n) begin
        ras_falls++;
        if (!p_cas && !cas_n) cbr_falls++;
        if (seen_rise && gap < min_gap) min_gap = gap;
      end
      if (!ras_n && !cas_n && !use_cbr && !cas_held) cas_ras_low++;
      if (ras_n) gap++;
      if (!p_ras && ras_n) begin gap = 1; seen_rise = 1; end
      if (int'(row_addr) != p_row) begin
        if (int'(row_addr) != (p_row + 1) % NROW) row_steps_bad++;
        if (row_addr == '0) wraps++;
      end
      p_ras = ras_n; p_cas = cas_n; p_row = int'(row_addr);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic wait_ready();
    while (!ready) step(1);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int t0, n;
    int r_before;
    min_gap = 1000; row_steps_bad = 0; wraps = 0; cas_ras_low = 0; m_ticks = 0;
    step(1);
    do_reset();
    step(20);
    chk("R1 ready low in pause", ready, 0);
    chk("R1 ras_n idle in pause", ras_n, 1);
    wait_ready();
    chk("R2 dummy cycles before ready", ras_falls, INIT);
    chk("R3 cbr init keeps row", row_addr, 0);
    chk("R4 cbr init cas setup", cbr_falls, INIT);
    t0 = cyc;
    while (!ref_req) step(1);
    chk("R7 normal interval", cyc - t0, INTV);

    // Backlog saturation and urgency
    step(INTV * 16);
    chk("R10 urgent when backlog full", ref_urgent, 1);
    ref_gnt = 1'b1;
    n = 0;
    t0 = ras_falls;
    step(1);
    while (ref_req || busy) step(1);
    n = ras_falls - t0;
    chk("R9 drain bounded by cap", (n >= BLMAX && n <= BLMAX + 4) ? 1 : 0, 1);

    // Steady column-before-row service
    step(300);

    // Row-only service through the counter wrap
    use_cbr = 1'b0;
    step(INTV * (NROW + 10));
    chk("R6 row counter wrapped", wraps >= 1 ? 1 : 0, 1);
    chk("R6 row counter steps", row_steps_bad, 0);
    chk("R5 row-only cas high", cas_ras_low, 0);

    // Hidden refresh in row-only mode
    ref_gnt = 1'b0;
    while (!ref_req) step(1);
    cas_held = 1'b1;
    ref_gnt = 1'b1;
    r_before = int'(row_addr);
    step(1);
    chk("R11 hidden ras immediate", ras_n, 0);
    chk("R11 hidden cas low", cas_n, 0);
    ref_gnt = 1'b0;
    cas_held = 1'b0;
    while (busy) step(1);
    chk("R11 hidden keeps row", row_addr, r_before);

    // Low-power interval
    low_power = 1'b1;
    ref_gnt = 1'b1;
    step(INTV * LPM * 2);
    ref_gnt = 1'b0;
    while (!ref_req) step(1);
    t0 = cyc;
    ref_gnt = 1'b1;
    while (!busy) step(1);
    ref_gnt = 1'b0;
    while (busy) step(1);
    while (!ref_req) step(1);
    chk("R7 low-power interval", cyc - t0, INTV * LPM);
    low_power = 1'b0;

    // Re-initialize in row-only mode
    do_reset();
    wait_ready();
    chk("R2 dummy cycles after second reset", ras_falls, INIT);
    chk("R3 row-only init advances row", row_addr, INIT);
    chk("R12 precharge gap", min_gap >= RP ? 1 : 0, 1);
    step(10);
    summary();
  end
endmodule